// File: doc/BRIEF.md
# EDO DRAM Read/Write Sequencer

This controller sits between a simple host port and a 32-bit EDO DRAM module. The module is built from two banks, each with its own active-low row strobe, and has four active-low column strobes that act as byte-lane selects. The host asks for one word at a time. It presents a 23-bit word address, a direction bit, write data and four byte enables, and it keeps its request high until an acknowledge pulse comes back. The sequencer then runs one complete row/column cycle on the DRAM pins and returns the read data registered together with that acknowledge.

Every DRAM minimum is given in nanoseconds as a parameter and converted to whole clock cycles, rounded up. The conversion covers row active time, precharge, full cycle time, strobe-to-strobe delay, row address hold, access from the column strobe, access from the column address and column hold. Writes always use the early-write form, so the data bus is driven only by the controller during a write. Refresh is issued by a separate scheduler. It asks for the pins through a request line and is granted only when this block is idle and its precharge is over.

Top module: `edo_seq`

## Requirements
- R1: While reset is held, both row strobes, all column strobes and write enable are high (inactive), the data output enable, acknowledge and refresh grant are low, and address bit 11 is low.
- R2: Host address bit 22 picks the bank. Bank 0 pulls row strobe bit 0 low and bank 1 pulls row strobe bit 1 low. At most one row strobe is ever low, and none is low while a refresh is granted.
- R3: The DRAM address carries the row (host address bits 21:11) in the first cycle the row strobe is low (1 cycle at default timing). From the next cycle on it carries the column (host address bits 10:0). Address bit 11 is always driven low.
- R4: Column strobes fall 2 cycles after the row strobe falls (default timing). A read lowers all four. A write lowers only those whose host byte enable is set, with column strobe bit i serving data byte i (bits 8i+7:8i).
- R5: At default timing the row strobe stays low for 5 cycles. The column strobes rise on the same edge as the row strobe.
- R6: After the strobes rise, the next row strobe fall comes no sooner than 4 cycles later, so the full cycle is at least 9 cycles. This holds even when the host keeps its request high across the acknowledge.
- R7: A write drives write enable low and the data output enable high, with the host's write data on the data output, from the row strobe fall until the strobes rise. A read keeps write enable high and the output enable low.
- R8: Read data is taken from the data input on the edge that ends the fourth cycle of the row strobe at default timing. It is presented on the host read-data port with the acknowledge and held afterward.
- R9: The acknowledge is high for exactly one cycle, the cycle right after the strobes rise.
- R10: A refresh request is granted only when the sequencer is idle and its precharge count has expired. It wins over a host request pending at the same time. The grant stays high until the request drops, and after that a full row precharge (3 cycles at default timing) passes before the next row strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Host request, held until acknowledge |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 23 | Word address: bit 22 bank, 21:11 row, 10:0 column |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte enables for writes |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data |
| refr_req | input | 1 | Refresh scheduler asks for the DRAM |
| refr_gnt | output | 1 | DRAM handed to the refresh scheduler |
| ras_n | output | 2 | Active-low row strobes, one per bank |
| cas_n | output | 4 | Active-low column strobes, one per byte |
| dram_a | output | 12 | Multiplexed address; bit 11 held low |
| we_n | output | 1 | Active-low write enable |
| dq_out | output | 32 | Data toward the DRAM |
| dq_oe | output | 1 | Output enable for dq_out |
| dq_in | input | 32 | Data from the DRAM |

## Verification
The data input pattern changes every cycle, so a capture one edge early or one edge late returns a different word and shows up in the read-data comparison. Back-to-back requests with the request held across the acknowledge test whether precharge is enforced. A design that dropped it would fire the next row strobe too soon and break the 9-cycle spacing. Refresh requests are raised both during an access and in the same cycle as a host request. A design that granted refresh mid-cycle, before precharge, or behind the host request would show a grant at the wrong time or row strobes low during the grant. Writes with partial and empty byte enables check that only the enabled lanes strobe, while reads strobe all four.

// File: rtl/edo_seq.sv
module edo_seq #(
  parameter int CLK_NS    = 10,
  parameter int T_RAS_NS  = 50,
  parameter int T_RP_NS   = 30,
  parameter int T_RC_NS   = 90,
  parameter int T_RCD_NS  = 20,
  parameter int T_RAH_NS  = 10,
  parameter int T_CAC_NS  = 13,
  parameter int T_AA_NS   = 25,
  parameter int T_CAS_NS  = 8,
  parameter int T_DH_NS   = 8,
  parameter int AW        = 23,
  parameter int DW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [3:0]    host_be,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  input  logic          refr_req,
  output logic          refr_gnt,
  output logic [1:0]    ras_n,
  output logic [3:0]    cas_n,
  output logic [11:0]   dram_a,
  output logic          we_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);
  localparam int HALF    = (AW - 1) / 2;
  localparam int RAS_C   = (T_RAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int RP_C0   = (T_RP_NS  + CLK_NS - 1) / CLK_NS;
  localparam int RP_C    = (RP_C0 < 1) ? 1 : RP_C0;
  localparam int RC_C    = (T_RC_NS  + CLK_NS - 1) / CLK_NS;
  localparam int RAH_C0  = (T_RAH_NS + CLK_NS - 1) / CLK_NS;
  localparam int RAH_C   = (RAH_C0 < 1) ? 1 : RAH_C0;
  localparam int RCD_C0  = (T_RCD_NS + CLK_NS - 1) / CLK_NS;
  localparam int RCD_C   = (RCD_C0 < RAH_C) ? RAH_C : RCD_C0;
  localparam int CAC_C   = (T_CAC_NS + CLK_NS - 1) / CLK_NS;
  localparam int AA_C    = (T_AA_NS  + CLK_NS - 1) / CLK_NS;
  localparam int CAS_C   = (T_CAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int DH_C    = (T_DH_NS  + CLK_NS - 1) / CLK_NS;
  localparam int CAP_A   = RCD_C + CAC_C;
  localparam int CAP_B   = RAH_C + AA_C;
  localparam int CAP_E   = (CAP_A > CAP_B) ? CAP_A : CAP_B;
  localparam int HOLD_C  = (CAS_C > DH_C) ? CAS_C : DH_C;
  localparam int END_A   = (RAS_C > CAP_E) ? RAS_C : CAP_E;
  localparam int END_B   = RCD_C + ((HOLD_C < 1) ? 1 : HOLD_C);
  localparam int END_E   = (END_A > END_B) ? END_A : END_B;
  localparam int PRE_C   = (RP_C > RC_C - END_E) ? RP_C : RC_C - END_E;
  localparam int CW      = $clog2(END_E + 1) + 1;
  localparam int PW      = $clog2(PRE_C + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_REF} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;
  logic [PW-1:0] pcnt;
  logic [HALF-1:0] col_q;
  logic [3:0]    lanes_q;
  logic          wr_q;

  assign cnt_nx = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      pcnt       <= '0;
      col_q      <= '0;
      lanes_q    <= 4'hF;
      wr_q       <= 1'b0;
      ras_n      <= 2'b11;
      cas_n      <= 4'hF;
      dram_a     <= '0;
      we_n       <= 1'b1;
      dq_oe      <= 1'b0;
      dq_out     <= '0;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      refr_gnt   <= 1'b0;
    end else begin
      host_ack <= 1'b0;
      case (st)
        S_IDLE: begin
          if (pcnt != '0) begin
            pcnt <= pcnt - 1'b1;
          end else if (refr_req) begin
            st       <= S_REF;
            refr_gnt <= 1'b1;
          end else if (host_req) begin
            st      <= S_ACT;
            cnt     <= '0;
            ras_n   <= host_addr[AW-1] ? 2'b01 : 2'b10;
            dram_a  <= {1'b0, host_addr[2*HALF-1:HALF]};
            col_q   <= host_addr[HALF-1:0];
            wr_q    <= host_wr;
            lanes_q <= host_wr ? host_be : 4'hF;
            we_n    <= ~host_wr;
            dq_oe   <= host_wr;
            dq_out  <= host_wdata;
          end
        end
        S_ACT: begin
          cnt <= cnt_nx;
          if (cnt_nx == CW'(RAH_C)) dram_a <= {1'b0, col_q};
          if (cnt_nx == CW'(RCD_C)) cas_n <= ~lanes_q;
          if (cnt_nx == CW'(CAP_E) && !wr_q) host_rdata <= dq_in;
          if (cnt_nx == CW'(END_E)) begin
            ras_n    <= 2'b11;
            cas_n    <= 4'hF;
            we_n     <= 1'b1;
            dq_oe    <= 1'b0;
            host_ack <= 1'b1;
            st       <= S_IDLE;
            pcnt     <= PW'(PRE_C - 1);
          end
        end
        S_REF: begin
          if (!refr_req) begin
            refr_gnt <= 1'b0;
            st       <= S_IDLE;
            pcnt     <= PW'(RP_C - 1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_seq_chk.sv
module edo_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  ras_n,
  input logic [3:0]  cas_n,
  input logic [11:0] dram_a,
  input logic        we_n,
  input logic        dq_oe,
  input logic        host_ack,
  input logic        refr_gnt
);
  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~ras_n));
  // R3
  a11_low_chk: assert property (@(posedge clk) disable iff (!rst_n) dram_a[11] == 1'b0);
  // R4
  cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n) (cas_n != 4'hF) |-> (ras_n != 2'b11));
  // R7
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> (!we_n && ras_n != 2'b11));
  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) host_ack |=> !host_ack);
  // R9
  ack_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(host_ack) |-> (ras_n == 2'b11 && $past(ras_n) != 2'b11));
  // R10
  gnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) refr_gnt |-> (ras_n == 2'b11 && cas_n == 4'hF && !dq_oe));
  // R6
  no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(host_ack) |-> ras_n == 2'b11 ##1 ras_n == 2'b11);
endmodule

bind edo_seq edo_seq_chk edo_seq_chk_i (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .dram_a(dram_a),
  .we_n(we_n), .dq_oe(dq_oe), .host_ack(host_ack), .refr_gnt(refr_gnt)
);

// File: tb/edo_seq_test.sv
module edo_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [22:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [3:0]  host_be = '0;
  logic        host_ack;
  logic [31:0] host_rdata;
  logic        refr_req = 1'b0, refr_gnt;
  logic [1:0]  ras_n;
  logic [3:0]  cas_n;
  logic [11:0] dram_a;
  logic        we_n, dq_oe;
  logic [31:0] dq_out;
  logic [31:0] dq_in = '0;

  int total = 0, bad = 0, ncyc = 0;

  always #5 clk = ~clk;

  edo_seq uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
    .host_ack(host_ack), .host_rdata(host_rdata), .refr_req(refr_req),
    .refr_gnt(refr_gnt), .ras_n(ras_n), .cas_n(cas_n), .dram_a(dram_a),
    .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // reference model: 0 idle, 1 access, 2 refresh
  int m_mode = 0, m_k = 0, m_pre = 0;
  logic m_bank, m_wr, e_ack;
  logic [10:0] m_row, m_col;
  logic [3:0]  m_lanes;
  logic [31:0] m_wdata, e_rdata;
  int last_fall = -100, last_rise = -100;

  always @(posedge clk) begin
    ncyc++;
    if (!rst_n) begin
      m_mode = 0; m_k = 0; m_pre = 0; e_ack = 0; e_rdata = '0;
    end else begin
      e_ack = 0;
      if (m_mode == 1) begin
        if (m_k == 3 && !m_wr) e_rdata = dq_in;
        m_k++;
        if (m_k == 5) begin m_mode = 0; m_pre = 3; e_ack = 1; last_rise = ncyc; end
      end else if (m_mode == 2) begin
        if (!refr_req) begin m_mode = 0; m_pre = 2; end
      end else if (m_pre > 0) begin
        m_pre--;
      end else if (refr_req) begin
        m_mode = 2;
      end else if (host_req) begin
        m_mode = 1; m_k = 0;
        m_bank = host_addr[22]; m_row = host_addr[21:11]; m_col = host_addr[10:0];
        m_wr = host_wr; m_lanes = host_wr ? host_be : 4'hF; m_wdata = host_wdata;
        last_fall = ncyc;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tag, ncyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    dq_in <= 32'h9E3779B9 * ncyc;
    if (!rst_n) begin
      // R1
      check("R1 ras", {30'd0, ras_n}, 32'd3);
      check("R1 cas", {28'd0, cas_n}, 32'hF);
      check("R1 we/oe/ack/gnt", {28'd0, we_n, dq_oe, host_ack, refr_gnt}, 32'h8);
      check("R1 a11", {31'd0, dram_a[11]}, 32'd0);
    end else begin
      check("R2/R5/R6 ras", {30'd0, ras_n},
            (m_mode == 1) ? (m_bank ? 32'd1 : 32'd2) : 32'd3);
      check("R4 cas", {28'd0, cas_n},
            (m_mode == 1 && m_k >= 2) ? {28'd0, ~m_lanes} : 32'hF);
      check("R3 a11", {31'd0, dram_a[11]}, 32'd0);
      if (m_mode == 1)
        check("R3 addr", {21'd0, dram_a[10:0]}, {21'd0, (m_k < 1) ? m_row : m_col});
      check("R7 we_n", {31'd0, we_n}, (m_mode == 1) ? {31'd0, ~m_wr} : 32'd1);
      check("R7 oe", {31'd0, dq_oe}, (m_mode == 1) ? {31'd0, m_wr} : 32'd0);
      if (m_mode == 1 && m_wr) check("R7 dq_out", dq_out, m_wdata);
      check("R9 ack", {31'd0, host_ack}, {31'd0, e_ack});
      if (e_ack && !m_wr) check("R8 rdata", host_rdata, e_rdata);
      check("R10 gnt", {31'd0, refr_gnt}, (m_mode == 2) ? 32'd1 : 32'd0);
    end
  end

  task automatic op(input logic wr, input logic [22:0] a, input logic [31:0] d,
                    input logic [3:0] be, input logic keep);
    host_wr = wr; host_addr = a; host_wdata = d; host_be = be; host_req = 1'b1;
    do @(negedge clk); while (!host_ack);
    if (!keep) host_req = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    op(1'b0, 23'h000ABC, '0, 4'h0, 1'b0);                // R2 bank 0 read
    repeat (3) @(negedge clk);
    op(1'b0, 23'h5A5F0F, '0, 4'h0, 1'b0);                // bank 1 read
    repeat (6) @(negedge clk);
    op(1'b1, 23'h312345, 32'hDEADBEEF, 4'hF, 1'b0);      // R7 full write
    repeat (6) @(negedge clk);
    op(1'b1, 23'h0FFFFF, 32'h12345678, 4'h5, 1'b0);      // R4 partial lanes
    repeat (6) @(negedge clk);
    op(1'b1, 23'h400001, 32'hCAFEF00D, 4'h0, 1'b1);      // no lanes, held request
    op(1'b0, 23'h7FFFFF, '0, 4'h0, 1'b1);                // R6 back-to-back
    op(1'b1, 23'h000000, 32'h0BADCAFE, 4'hA, 1'b0);
    // R10 refresh raised mid-access
    fork
      op(1'b0, 23'h2AAAAA, '0, 4'h0, 1'b0);
      begin repeat (2) @(negedge clk); refr_req = 1'b1; repeat (14) @(negedge clk); refr_req = 1'b0; end
    join
    repeat (2) @(negedge clk);
    // R10 refresh and host request together: refresh first
    fork
      op(1'b0, 23'h155555, '0, 4'h0, 1'b0);
      begin refr_req = 1'b1; repeat (5) @(negedge clk); refr_req = 1'b0; end
    join
    repeat (8) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule